// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block decides where the program counter goes on three kinds of event: the first cycle after reset, entry into an exception handler, and return from a handler. It takes the current PC, a request kind and a vector offset. It holds the privileged base register and the saved restart address. It drives a new PC, the following PC and a one-cycle redirect pulse. It also raises pulses for an illegal return attempt and for request kinds it does not support.

Bit 0 of any PC value is the privileged-mode flag. A handler entry sets it. A return takes it from bit 0 of the saved restart address. Bit 1 of the saved address is always stored as zero.

Requests use a valid/ready handshake. A request is consumed on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low only in the single cycle in which the reset redirect is issued. A request held during that cycle is neither taken nor lost: the source keeps it, or changes it, freely. All results are registered and appear in the cycle after the accepting edge.

Top module: `trap_sequencer`

## Requirements
- R1: In the first cycle after reset is released, `req_ready` is 0. At that edge the block pulses `redir_valid` with `new_pc` = (base + RESET_VEC) with bit 0 set, `next_pc` = `new_pc` + 4 and `priv_mode` = 1. A request offered in that cycle has no effect.
- R2: An accepted request of kind 0 (post), 1 (interrupt), 2 (privileged call) or 3 (fault) gives, one cycle later, a single `redir_valid` pulse. In that cycle `new_pc` = (base + `vec_off`) with bit 0 set, `next_pc` = `new_pc` + 4 and `priv_mode` = 1.
- R3: An accepted kind 0 or kind 2 request saves `cur_pc` + 4, with bit 1 cleared, into the restart address.
- R4: An accepted kind 3 request saves `cur_pc`, with bit 1 cleared, into the restart address.
- R5: An accepted kind 1 request saves `cur_pc` (bit 1 cleared) when `cur_pc[0]` is 0. It leaves the restart address unchanged when `cur_pc[0]` is 1.
- R6: An accepted kind 5 (return) request with `cur_pc[0]` = 1 gives, one cycle later, a `redir_valid` pulse and an `intr_rearm` pulse. In that cycle `new_pc` = `cur_pc`, `next_pc` = the saved restart address and `priv_mode` = its bit 0.
- R7: An accepted kind 5 request with `cur_pc[0]` = 0 pulses `illegal_op`. There is no redirect and the restart address is left unchanged.
- R8: An accepted request of kind 4 (arithmetic) or of the unused codes 6 and 7 pulses `unsupported`. There is no redirect and the restart address is left unchanged.
- R9: A base write (`base_wr_en`) takes effect for requests accepted on later edges. A request accepted on the same edge uses the old base.
- R10: While `rst_n` is low, all outputs are 0. With `req_valid` low, no pulse is produced and the restart address is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 3 | Request kind code (see R2 to R8) |
| cur_pc | input | AW | PC of the instruction raising the request; bit 0 is the privileged flag |
| vec_off | input | VW | Handler vector offset, added to the base |
| base_wr_en | input | 1 | Load the privileged base register |
| base_wr_data | input | AW | New base value |
| redir_valid | output | 1 | One-cycle redirect pulse |
| new_pc | output | AW | Redirected PC |
| next_pc | output | AW | PC following the redirect |
| priv_mode | output | 1 | Privileged-mode flag after the last redirect |
| intr_rearm | output | 1 | Pulse: interrupt checking re-armed on return |
| illegal_op | output | 1 | Pulse: return attempted outside privileged mode |
| unsupported | output | 1 | Pulse: unsupported request kind |
| exc_addr | output | AW | Saved restart address |

## Verification
Handler entry is tried with every entry kind, from PCs with bit 0 clear and with bit 0 set, and from a PC with bit 1 set. Each pattern separates the skip-ahead save, the restart save and the kept address, and shows that bit 1 is cleared when an address is saved. Returns are issued both in and out of privileged mode, after saves with bit 0 clear and with bit 0 set, to show where `priv_mode` is taken from. A base write on the same edge as a request, followed by one on a later edge, checks which base value each request uses. Requests are also offered in the reset redirect cycle and with `req_valid` low, to show that the handshake gates them.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    K_POST  = 3'd0,
    K_INTR  = 3'd1,
    K_PCALL = 3'd2,
    K_FAULT = 3'd3,
    K_ARITH = 3'd4,
    K_ERET  = 3'd5
  } trap_kind_e;
endpackage

// File: rtl/trap_epc_sel.sv
module trap_epc_sel #(
  parameter int AW = 32
) (
  input  logic [2:0]    kind,
  input  logic [AW-1:0] cur_pc,
  output logic          load,
  output logic [AW-1:0] value
);
  import trap_pkg::*;
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [AW-1:0] B1   = AW'(2);

  logic [AW-1:0] raw;

  always_comb begin
    load = 1'b0;
    raw  = cur_pc;
    case (trap_kind_e'(kind))
      K_POST, K_PCALL: begin load = 1'b1; raw = cur_pc + STEP; end
      K_FAULT:         begin load = 1'b1; raw = cur_pc; end
      K_INTR:          begin load = ~cur_pc[0]; raw = cur_pc; end
      default:         begin load = 1'b0; raw = cur_pc; end
    endcase
    value = raw & ~B1;
  end
endmodule

// File: rtl/trap_target.sv
module trap_target #(
  parameter int AW = 32,
  parameter int VW = 16,
  parameter logic [VW-1:0] RESET_VEC = '0
) (
  input  logic [AW-1:0] base,
  input  logic [VW-1:0] vec,
  output logic [AW-1:0] entry_pc,
  output logic [AW-1:0] boot_pc
);
  localparam int PAD = AW - VW;
  localparam logic [AW-1:0] PRIV = AW'(1);

  assign entry_pc = (base + {{PAD{1'b0}}, vec}) | PRIV;
  assign boot_pc  = (base + {{PAD{1'b0}}, RESET_VEC}) | PRIV;
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer #(
  parameter int AW = 32,
  parameter int VW = 16,
  parameter logic [AW-1:0] RESET_BASE = 32'h0001_0000,
  parameter logic [VW-1:0] RESET_VEC  = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] cur_pc,
  input  logic [VW-1:0] vec_off,
  input  logic          base_wr_en,
  input  logic [AW-1:0] base_wr_data,
  output logic          redir_valid,
  output logic [AW-1:0] new_pc,
  output logic [AW-1:0] next_pc,
  output logic          priv_mode,
  output logic          intr_rearm,
  output logic          illegal_op,
  output logic          unsupported,
  output logic [AW-1:0] exc_addr
);
  import trap_pkg::*;
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [AW-1:0] B1   = AW'(2);

  logic          boot_q;
  logic [AW-1:0] base_q;
  logic          fire;
  logic          epc_load;
  logic [AW-1:0] epc_val, entry_pc, boot_pc;

  assign req_ready = ~boot_q;
  assign fire      = req_valid & req_ready;

  trap_epc_sel #(.AW(AW)) u_epc (
    .kind(req_kind), .cur_pc(cur_pc), .load(epc_load), .value(epc_val)
  );

  trap_target #(.AW(AW), .VW(VW), .RESET_VEC(RESET_VEC)) u_tgt (
    .base(base_q), .vec(vec_off), .entry_pc(entry_pc), .boot_pc(boot_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q      <= 1'b1;
      base_q      <= RESET_BASE;
      redir_valid <= 1'b0;
      new_pc      <= '0;
      next_pc     <= '0;
      priv_mode   <= 1'b0;
      intr_rearm  <= 1'b0;
      illegal_op  <= 1'b0;
      unsupported <= 1'b0;
      exc_addr    <= '0;
    end else begin
      boot_q      <= 1'b0;
      redir_valid <= 1'b0;
      intr_rearm  <= 1'b0;
      illegal_op  <= 1'b0;
      unsupported <= 1'b0;
      if (base_wr_en) base_q <= base_wr_data;
      if (boot_q) begin
        redir_valid <= 1'b1;
        new_pc      <= boot_pc;
        next_pc     <= boot_pc + STEP;
        priv_mode   <= 1'b1;
      end else if (fire) begin
        case (trap_kind_e'(req_kind))
          K_POST, K_INTR, K_PCALL, K_FAULT: begin
            redir_valid <= 1'b1;
            new_pc      <= entry_pc;
            next_pc     <= entry_pc + STEP;
            priv_mode   <= 1'b1;
            if (epc_load) exc_addr <= epc_val;
          end
          K_ERET: begin
            if (cur_pc[0]) begin
              redir_valid <= 1'b1;
              intr_rearm  <= 1'b1;
              new_pc      <= cur_pc;
              next_pc     <= exc_addr;
              priv_mode   <= exc_addr[0];
            end else begin
              illegal_op  <= 1'b1;
            end
          end
          default: unsupported <= 1'b1;
        endcase
      end
    end
  end

  // R1
  boot_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> redir_valid && priv_mode && next_pc == new_pc + STEP);

  // R2
  entry_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_kind < 3'd4 |=> redir_valid && new_pc[0] && next_pc == new_pc + STEP);

  // R4
  fault_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_kind == 3'd3 |=> exc_addr == ($past(cur_pc) & ~B1));

  // R5
  intr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_kind == 3'd1 && cur_pc[0] |=> $stable(exc_addr));

  // R6
  eret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_kind == 3'd5 && cur_pc[0] |=> next_pc == $past(exc_addr) && intr_rearm);

  // R7
  eret_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_kind == 3'd5 && !cur_pc[0] |=> illegal_op && !redir_valid);

  // R8
  unsupp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (req_kind == 3'd4 || req_kind > 3'd5) |=> unsupported && !redir_valid && $stable(exc_addr));

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({redir_valid, illegal_op, unsupported}) <= 1);
endmodule

// File: tb/test_trap_sequencer.sv
module test_trap_sequencer;
  localparam int AW = 32;
  localparam int VW = 16;
  localparam logic [AW-1:0] RB = 32'h0001_0000;
  localparam logic [VW-1:0] RV = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [AW-1:0] cur_pc = '0;
  logic [VW-1:0] vec_off = '0;
  logic base_wr_en = 1'b0;
  logic [AW-1:0] base_wr_data = '0;
  logic req_ready, redir_valid, priv_mode, intr_rearm, illegal_op, unsupported;
  logic [AW-1:0] new_pc, next_pc, exc_addr;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic rv; logic [AW-1:0] npc; logic [AW-1:0] nxpc; logic prv;
    logic rearm; logic ill; logic uns; logic [AW-1:0] exc; string tag;
  } exp_t;
  exp_t exp_q[$];

  logic [AW-1:0] m_base = RB;
  logic [AW-1:0] m_exc = '0;
  logic m_prv = 1'b0;

  always #5 clk = ~clk;

  trap_sequencer #(.AW(AW), .VW(VW), .RESET_BASE(RB), .RESET_VEC(RV)) i_trap_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .cur_pc(cur_pc), .vec_off(vec_off),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .redir_valid(redir_valid), .new_pc(new_pc), .next_pc(next_pc),
    .priv_mode(priv_mode), .intr_rearm(intr_rearm), .illegal_op(illegal_op),
    .unsupported(unsupported), .exc_addr(exc_addr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic exp_t quiet(input string tag);
    exp_t e;
    e.rv = 0; e.npc = '0; e.nxpc = '0; e.prv = m_prv; e.rearm = 0;
    e.ill = 0; e.uns = 0; e.exc = m_exc; e.tag = tag;
    return e;
  endfunction

  // driver: offers one request and pushes its expected result
  task automatic send(input logic [2:0] k, input logic [AW-1:0] pc,
                      input logic [VW-1:0] vec, input bit bw,
                      input logic [AW-1:0] bwd, input string tag);
    exp_t e;
    logic [AW-1:0] ent;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; cur_pc = pc; vec_off = vec;
    base_wr_en = bw; base_wr_data = bwd;
    e = quiet(tag);
    ent = (m_base + {16'h0, vec}) | 32'h1;
    if (k <= 3'd3) begin
      e.rv = 1; e.npc = ent; e.nxpc = ent + 32'd4; e.prv = 1;
      if (k == 3'd0 || k == 3'd2) e.exc = (pc + 32'd4) & ~32'h2;
      else if (k == 3'd3) e.exc = pc & ~32'h2;
      else if (!pc[0]) e.exc = pc & ~32'h2;
    end else if (k == 3'd5) begin
      if (pc[0]) begin
        e.rv = 1; e.npc = pc; e.nxpc = m_exc; e.prv = m_exc[0]; e.rearm = 1;
      end else e.ill = 1;
    end else e.uns = 1;
    m_exc = e.exc; m_prv = e.prv;
    if (bw) m_base = bwd;
    exp_q.push_back(e);
  endtask

  task automatic idle(input logic [2:0] k, input string tag);
    @(negedge clk);
    req_valid = 1'b0; req_kind = k; cur_pc = 32'h0000_9000; base_wr_en = 1'b0;
    exp_q.push_back(quiet(tag));
  endtask

  // monitor: compares each cycle's result with the head of the queue
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(redir_valid == e.rv, e.tag, "redir_valid", AW'(redir_valid), AW'(e.rv));
      if (e.rv) begin
        chk(new_pc == e.npc, e.tag, "new_pc", new_pc, e.npc);
        chk(next_pc == e.nxpc, e.tag, "next_pc", next_pc, e.nxpc);
      end
      chk(priv_mode == e.prv, e.tag, "priv_mode", AW'(priv_mode), AW'(e.prv));
      chk(intr_rearm == e.rearm, e.tag, "intr_rearm", AW'(intr_rearm), AW'(e.rearm));
      chk(illegal_op == e.ill, e.tag, "illegal_op", AW'(illegal_op), AW'(e.ill));
      chk(unsupported == e.uns, e.tag, "unsupported", AW'(unsupported), AW'(e.uns));
      chk(exc_addr == e.exc, e.tag, "exc_addr", exc_addr, e.exc);
    end
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    // R10: outputs held at zero during reset
    chk({redir_valid, new_pc, next_pc, priv_mode, exc_addr} == '0, "R10", "reset outputs",
        AW'(redir_valid), AW'(0));
    // R1: boot redirect, request offered in this cycle is ignored
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1; req_kind = 3'd3; cur_pc = 32'h0000_4444; vec_off = 16'h0040;
    chk(req_ready == 1'b0, "R1", "req_ready in boot cycle", AW'(req_ready), AW'(0));
    e = quiet("R1");
    e.rv = 1; e.npc = (RB + {16'h0, RV}) | 32'h1; e.nxpc = e.npc + 32'd4; e.prv = 1;
    m_prv = 1;
    exp_q.push_back(e);

    send(3'd3, 32'h0000_2000, 16'h0080, 0, '0, "R2 R4 fault entry");
    send(3'd2, 32'h0000_3000, 16'h0040, 0, '0, "R3 pcall save");
    send(3'd0, 32'h0000_3008, 16'h0010, 0, '0, "R3 post save");
    send(3'd3, 32'h0000_4006, 16'h0080, 0, '0, "R4 bit1 cleared");
    send(3'd1, 32'h0000_5000, 16'h0020, 0, '0, "R5 intr user save");
    send(3'd1, 32'h0001_0091, 16'h0020, 0, '0, "R5 intr priv keep");
    send(3'd5, 32'h0001_00A1, 16'h0000, 0, '0, "R6 return to user");
    send(3'd5, 32'h0000_6000, 16'h0000, 0, '0, "R7 illegal return");
    send(3'd4, 32'h0000_7000, 16'h0030, 0, '0, "R8 arith");
    send(3'd7, 32'h0000_7004, 16'h0030, 0, '0, "R8 code 7");
    idle(3'd3, "R10 valid low");
    send(3'd3, 32'h0000_8000, 16'h0020, 1, 32'h0002_0000, "R9 same-edge old base");
    send(3'd3, 32'h0000_8100, 16'h0020, 0, '0, "R9 new base");
    send(3'd3, 32'h0001_00C1, 16'h0010, 0, '0, "R4 priv fault save");
    send(3'd5, 32'h0002_0031, 16'h0000, 0, '0, "R6 return stays priv");
    idle(3'd0, "R10 idle");
    idle(3'd0, "R10 idle");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule